// File: doc/BRIEF.md
# Conversion Auto-Trigger Selector

This block sits in front of an analog-to-digital conversion sequencer. It picks one of eight trigger signals with a 3-bit select code and turns a rising edge of that signal into a one-cycle start request. Code 0 is the free-running mode. In that mode the signal is the sequencer's own done flag, so each completed conversion requests the next one. Codes 1 to 7 pick level-type interrupt flags from other peripherals: a comparator, an external interrupt, and several timer events. Those flags arrive on a plain input vector.

Edge detection happens after the multiplexer. The previous value of the selected signal is registered every cycle, including cycles where the select code changes. As a result, moving the select from a low source to a high source counts as a rising edge. Moving into free-running mode never counts as a trigger, even when the done flag is already high.

Start requests are produced only when both the converter-enable and auto-trigger-enable inputs are high. An edge that arrives while the sequencer reports busy is dropped, not held for later.

Top module: `atrig_select`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `start_req` is 0.
- R2: With `trig_sel` = 0 (free-running), each rising edge of `conv_done` sampled at a clock edge makes `start_req` 1 for the following cycle.
- R3: With `trig_sel` = c, for c from 1 to 7, the trigger signal is `trig_flags[c]` (1 comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 1 compare B, 6 timer 1 overflow, 7 timer 1 capture). The other flag bits have no effect.
- R4: Only a 0-to-1 change of the selected signal triggers. A signal held high gives exactly one pulse, and a falling edge gives none.
- R5: When `auto_en` is 0, no pulse is produced, whatever the select code and flags. A flag that rose while `auto_en` was 0 does not pulse later when `auto_en` is set.
- R6: When `conv_en` is 0, no pulse is produced.
- R7: Changing `trig_sel` from a source whose signal is 0 to one whose signal is 1 produces a pulse. Changing between two sources that are both 1 does not.
- R8: Changing `trig_sel` from a nonzero code to 0 produces no pulse, even when `conv_done` is 1.
- R9: A trigger edge seen while `conv_busy` is 1 is dropped. No pulse follows when busy clears while the signal stays high.
- R10: `start_req` is registered. It rises in the cycle after the edge is sampled and is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter enabled |
| auto_en | input | 1 | Auto-trigger enabled |
| conv_busy | input | 1 | Sequencer is converting |
| trig_sel | input | 3 | Trigger source code |
| trig_flags | input | 7 | Interrupt flags for codes 1..7 (index = code) |
| conv_done | input | 1 | Sequencer done flag, free-running source |
| start_req | output | 1 | One-cycle conversion start request |

## Verification
The bench attacks the select-change corners. It moves from a low source to a high one, which must pulse. It moves between two high sources and moves into free-running mode with the done flag high, neither of which may pulse. A design that registered the previous value per source, or that froze it on select changes, would miss the first case or fire on the others. A held-high flag, an edge during busy, and an edge while auto-trigger is off are all followed by cycles where the flag stays high. A design that queued the event, or that stopped tracking while gated, would emit a late pulse in those cycles.

// File: rtl/atrig_pkg.sv
package atrig_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        TRIG_FREE     = 3'd0,
        TRIG_ACMP     = 3'd1,
        TRIG_EXT0     = 3'd2,
        TRIG_T0_CMPA  = 3'd3,
        TRIG_T0_OVF   = 3'd4,
        TRIG_T1_CMPB  = 3'd5,
        TRIG_T1_OVF   = 3'd6,
        TRIG_T1_CAPT  = 3'd7
    } trig_src_e;

    typedef struct packed {
        logic conv_en;
        logic auto_en;
        logic busy;
    } gate_t;

    function automatic logic gate_open(input gate_t g);
        return g.conv_en && g.auto_en && !g.busy;
    endfunction
endpackage

// File: rtl/atrig_mux.sv
module atrig_mux
    import atrig_pkg::*;
#(
    parameter int SW = SEL_W,
    localparam int N = 1 << SW
) (
    input  logic [SW-1:0] sel,
    input  logic [N-1:1]  flags,
    input  logic          done,
    output logic          sig,
    output logic          free_run
);
    logic [N-1:0] all_src;

    assign all_src[0] = done;
    for (genvar i = 1; i < N; i++) begin : g_src
        assign all_src[i] = flags[i];
    end

    assign sig      = all_src[sel];
    assign free_run = (sel == SW'(TRIG_FREE));
endmodule

// File: rtl/atrig_edge.sv
module atrig_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic free_run,
    output logic rise
);
    logic prev_sig;
    logic prev_fr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sig <= 1'b0;
            prev_fr  <= 1'b1;
        end else begin
            prev_sig <= sig;
            prev_fr  <= free_run;
        end
    end

    assign rise = sig && !prev_sig && !(free_run && !prev_fr);

    // R4: an edge needs the signal low one cycle before
    p_rise_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
        rise |-> !$past(sig) || $past(rst));
endmodule

// File: rtl/atrig_select.sv
module atrig_select
    import atrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_en,
    input  logic             auto_en,
    input  logic             conv_busy,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic [NUM_SRC-1:1] trig_flags,
    input  logic             conv_done,
    output logic             start_req
);
    logic  sel_sig;
    logic  sel_free;
    logic  sel_rise;
    gate_t gate;

    atrig_mux #(.SW(SEL_W)) u_mux (
        .sel      (trig_sel),
        .flags    (trig_flags),
        .done     (conv_done),
        .sig      (sel_sig),
        .free_run (sel_free)
    );

    atrig_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig      (sel_sig),
        .free_run (sel_free),
        .rise     (sel_rise)
    );

    assign gate = '{conv_en: conv_en, auto_en: auto_en, busy: conv_busy};

    always_ff @(posedge clk) begin
        if (rst) start_req <= 1'b0;
        else     start_req <= sel_rise && gate_open(gate);
    end

    // R1: quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !start_req);
    // R10: never two cycles in a row
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        start_req |=> !start_req);
    // R5: auto-trigger off blocks requests
    p_auto_off_r5: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> !start_req);
    // R6: converter off blocks requests
    p_conv_off_r6: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> !start_req);
    // R9: busy drops edges
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
        conv_busy |=> !start_req);
    // R8: entering free-running never triggers
    p_fr_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (trig_sel == TRIG_FREE && $past(trig_sel) != TRIG_FREE && !$past(rst))
            |=> !start_req);
endmodule

// File: tb/atrig_select_tb.sv
`timescale 1ns/1ps
module atrig_select_tb;
    import atrig_pkg::*;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_en = 1'b0;
    logic       auto_en = 1'b0;
    logic       conv_busy = 1'b0;
    logic [2:0] trig_sel = 3'd0;
    logic [7:1] trig_flags = '0;
    logic       conv_done = 1'b0;
    logic       start_req;

    item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    atrig_select u_dut (
        .clk(clk), .rst(rst), .conv_en(conv_en), .auto_en(auto_en),
        .conv_busy(conv_busy), .trig_sel(trig_sel), .trig_flags(trig_flags),
        .conv_done(conv_done), .start_req(start_req)
    );

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (start_req !== it.exp) begin
                fails++;
                $display("FAIL %s start_req=%b expected=%b", it.tag, start_req, it.exp);
            end
        end
    end

    task automatic step(input logic r, input logic ae, input logic en, input logic bz,
                        input logic [2:0] sel, input logic [7:1] fl, input logic dn,
                        input logic exp, input string tag);
        @(negedge clk);
        rst = r; auto_en = ae; conv_en = en; conv_busy = bz;
        trig_sel = sel; trig_flags = fl; conv_done = dn;
        sb.push_back('{exp: exp, tag: tag});
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset
        step(1, 1, 1, 0, 3'd1, 7'h00, 0, 0, "R1");
        step(1, 1, 1, 0, 3'd1, 7'h7f, 0, 0, "R1");
        step(0, 1, 1, 0, 3'd1, 7'h00, 0, 0, "R1");
        // R3 / R4 every flag source
        for (int c = 1; c < 8; c++) begin
            logic [7:1] others;
            others = 7'h7f;
            others[c] = 1'b0;
            step(0, 1, 1, 0, 3'(c), others, 1, 0, "R3 other bits");
            step(0, 1, 1, 0, 3'(c), 7'h7f, 1, 1, "R3 selected rise");
            step(0, 1, 1, 0, 3'(c), 7'h7f, 1, 0, "R4 held high");
            step(0, 1, 1, 0, 3'(c), 7'h00, 0, 0, "R4 falling");
        end
        // R2 free-running
        step(0, 1, 1, 0, 3'd0, 7'h00, 0, 0, "R2");
        step(0, 1, 1, 0, 3'd0, 7'h00, 1, 1, "R2 done rise");
        step(0, 1, 1, 0, 3'd0, 7'h7f, 1, 0, "R2 held");
        step(0, 1, 1, 0, 3'd0, 7'h00, 0, 0, "R2");
        step(0, 1, 1, 0, 3'd0, 7'h00, 1, 1, "R2 second rise");
        // R8 enter free-running with done high
        step(0, 1, 1, 0, 3'd3, 7'h00, 1, 0, "R8 low source");
        step(0, 1, 1, 0, 3'd0, 7'h00, 1, 0, "R8 switch into free-run");
        step(0, 1, 1, 0, 3'd0, 7'h00, 1, 0, "R8 stays quiet");
        step(0, 1, 1, 0, 3'd0, 7'h00, 0, 0, "R2");
        step(0, 1, 1, 0, 3'd0, 7'h00, 1, 1, "R2 after re-entry");
        // R7 reselect
        step(0, 1, 1, 0, 3'd2, 7'h10, 0, 0, "R7 low source");
        step(0, 1, 1, 0, 3'd5, 7'h10, 0, 1, "R7 low to high");
        step(0, 1, 1, 0, 3'd2, 7'h10, 0, 0, "R7 back to low");
        step(0, 1, 1, 0, 3'd5, 7'h10, 0, 1, "R7 low to high again");
        step(0, 1, 1, 0, 3'd5, 7'h30, 0, 0, "R7");
        step(0, 1, 1, 0, 3'd6, 7'h30, 0, 0, "R7 high to high");
        // R5 auto-trigger off
        step(0, 0, 1, 0, 3'd1, 7'h00, 0, 0, "R5");
        step(0, 0, 1, 0, 3'd1, 7'h01, 0, 0, "R5 edge while off");
        step(0, 0, 1, 0, 3'd7, 7'h41, 0, 0, "R5 reselect while off");
        step(0, 1, 1, 0, 3'd7, 7'h41, 0, 0, "R5 enable with flag high");
        step(0, 1, 1, 0, 3'd7, 7'h00, 0, 0, "R5");
        step(0, 1, 1, 0, 3'd7, 7'h40, 0, 1, "R5 normal after");
        // R6 converter off
        step(0, 1, 0, 0, 3'd4, 7'h00, 0, 0, "R6");
        step(0, 1, 0, 0, 3'd4, 7'h08, 0, 0, "R6 edge while off");
        step(0, 1, 1, 0, 3'd4, 7'h08, 0, 0, "R6 enable with flag high");
        // R9 busy
        step(0, 1, 1, 1, 3'd4, 7'h00, 0, 0, "R9");
        step(0, 1, 1, 1, 3'd4, 7'h08, 0, 0, "R9 edge while busy");
        step(0, 1, 1, 0, 3'd4, 7'h08, 0, 0, "R9 not queued");
        step(0, 1, 1, 0, 3'd4, 7'h00, 0, 0, "R9");
        step(0, 1, 1, 0, 3'd4, 7'h08, 0, 1, "R9 edge when idle");
        step(0, 1, 1, 0, 3'd4, 7'h08, 0, 0, "R10 one cycle wide");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule